// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two independent interval timers behind a small 16-bit register bus. Each timer owns a 16-bit prescale value and a 16-bit divide value. It counts system clocks and emits a one-cycle interrupt pulse every (1 + prescale) × (1 + divide) cycles. After each pulse it reloads itself and starts the next period. The first timer is meant to pace audio samples and the second to pace musical tempo. Masking and latching of the pulses belong to an interrupt controller outside this block.

Software reaches the four 16-bit registers either as whole words or as single bytes, with big-endian byte order. Any write to a timer's register restarts that timer from the new values. A zero in either of its registers parks the timer.

Each timer runs a two-state machine. `TMR_IDLE` holds the counters at zero. `TMR_RUN` counts. The named transitions are:
- **load**: a register write with both values nonzero; from either state it goes to `TMR_RUN`.
- **halt**: a register write that leaves a zero in either register; from either state it goes to `TMR_IDLE`.
- **expire**: the period ends inside `TMR_RUN`; the timer stays in `TMR_RUN`, reloads and pulses.

Reset places both timers in `TMR_IDLE`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all four registers read 0xFFFF and neither timer produces a pulse until one of its registers is written.
- R2: With prescale P and divide D both nonzero, the first pulse of a timer appears (1+P)×(1+D) clock edges after the edge that accepted the write.
- R3: After each pulse the timer reloads on its own, and the following pulse comes exactly (1+P)×(1+D) edges later.
- R4: While the prescale or the divide of a timer is zero, that timer produces no pulse, including when the zero is written during a running period.
- R5: A word or byte write to either register of a timer restarts its period from the write edge, and that timer does not pulse on the cycle after the write.
- R6: Byte access is big-endian: byte address 2w selects bits 15:8 of word w and byte address 2w+1 selects bits 7:0. A byte write changes only its own half, and a byte read returns the selected half in bits 7:0 with bits 15:8 zero.
- R7: The words are laid out in this order: word 0 is timer 1 prescale, word 1 is timer 1 divide, word 2 is timer 2 prescale and word 3 is timer 2 divide (byte addresses 0–7). Each word reads back the last value written to it.
- R8: Each interrupt output is high for exactly one clock cycle per expiry.
- R9: The timers are independent: a write to one timer neither restarts nor shifts the other timer's pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the timers count its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access (data in bits 7:0) |
| bus_addr | input | 3 | Byte address; bit 0 picks the byte, the upper bits pick the word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr and bus_word (combinational) |
| irq_pulse | output | 2 | Bit 0 is the timer 1 (sample) pulse and bit 1 is the timer 2 (tempo) pulse |

## Verification
The hardest situation to reach is a register write that lands close to an expiry, or on a timer that is already running. In that case the restart has to win over the reload and suppress the pulse that was about to fire. The stimulus starts a timer with a known period and waits a fixed number of cycles into that period. It then rewrites a register with a word access, and later with a byte access, and measures the delay to the next pulse from the write edge. A similar sequence writes a zero into a running timer. A two-timer sequence starts the second timer and then writes the first, to show that the second timer's phase does not move.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/dit_regfile.sv
module dit_regfile
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    localparam int NUM_REGS  = NUM_TIMERS * 2,
    localparam int ADDR_W    = $clog2(NUM_REGS) + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic                              bus_word,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [REG_W-1:0]                  bus_wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0]    reg_q,
    output logic [NUM_REGS-1:0][REG_W-1:0]    reg_nxt,
    output logic [NUM_TIMERS-1:0]             restart
);
    logic [NUM_REGS-1:0] hit;

    for (genvar w = 0; w < NUM_REGS; w++) begin : g_reg
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * w);
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * w + 1);

        logic hit_word;
        logic hit_hi;
        logic hit_lo;

        always_comb begin
            hit_word = bus_wr && bus_word && (bus_addr[ADDR_W-1:1] == HI_ADDR[ADDR_W-1:1]);
            hit_hi   = bus_wr && !bus_word && (bus_addr == HI_ADDR);
            hit_lo   = bus_wr && !bus_word && (bus_addr == LO_ADDR);
            hit[w]   = hit_word || hit_hi || hit_lo;
        end

        always_comb begin
            reg_nxt[w] = reg_q[w];
            if (hit_word) begin
                reg_nxt[w] = bus_wdata;
            end else if (hit_hi) begin
                reg_nxt[w] = {bus_wdata[BYTE_W-1:0], reg_q[w][BYTE_W-1:0]};
            end else if (hit_lo) begin
                reg_nxt[w] = {reg_q[w][REG_W-1:BYTE_W], bus_wdata[BYTE_W-1:0]};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[w] <= '1;
            end else begin
                reg_q[w] <= reg_nxt[w];
            end
        end
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_restart
        assign restart[t] = hit[2*t] || hit[2*t+1];
    end
endmodule

// File: rtl/dit_timer_core.sv
module dit_timer_core
    import dit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [REG_W-1:0] presc_nxt,
    input  logic [REG_W-1:0] div_nxt,
    output logic             irq
);
    tmr_state_e       state_q, state_d;
    logic [REG_W-1:0] pcnt_q, pcnt_d;
    logic [REG_W-1:0] dcnt_q, dcnt_d;
    logic             irq_q, irq_d;
    logic             cfg_zero;
    logic             pre_wrap;
    logic             div_wrap;

    assign cfg_zero = (presc_nxt == '0) || (div_nxt == '0);
    assign pre_wrap = (pcnt_q == '0);
    assign div_wrap = pre_wrap && (dcnt_q == '0);

    // next-state: load, halt, expire
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = cfg_zero ? TMR_IDLE : TMR_RUN;
        end else begin
            unique case (state_q)
                TMR_IDLE: state_d = TMR_IDLE;
                TMR_RUN:  state_d = TMR_RUN;
                default:  state_d = TMR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and pulse; a restart takes priority over an expiry
    always_comb begin
        pcnt_d = pcnt_q;
        dcnt_d = dcnt_q;
        irq_d  = 1'b0;
        if (restart) begin
            pcnt_d = cfg_zero ? '0 : presc_nxt;
            dcnt_d = cfg_zero ? '0 : div_nxt;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    pcnt_d = '0;
                    dcnt_d = '0;
                end
                TMR_RUN: begin
                    if (pre_wrap) begin
                        pcnt_d = presc_nxt;
                        dcnt_d = div_wrap ? div_nxt : dcnt_q - 1'b1;
                        irq_d  = div_wrap;
                    end else begin
                        pcnt_d = pcnt_q - 1'b1;
                    end
                end
                default: begin
                    pcnt_d = '0;
                    dcnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pcnt_q <= pcnt_d;
            dcnt_q <= dcnt_d;
            irq_q  <= irq_d;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/dit_readmux.sv
module dit_readmux
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    localparam int NUM_REGS  = NUM_TIMERS * 2,
    localparam int ADDR_W    = $clog2(NUM_REGS) + 1
) (
    input  logic [NUM_REGS-1:0][REG_W-1:0] reg_q,
    input  logic                           bus_word,
    input  logic [ADDR_W-1:0]              bus_addr,
    output logic [REG_W-1:0]               bus_rdata
);
    logic [REG_W-1:0] sel;

    always_comb begin
        sel = reg_q[bus_addr[ADDR_W-1:1]];
        if (bus_word) begin
            bus_rdata = sel;
        end else if (bus_addr[0]) begin
            bus_rdata = {{BYTE_W{1'b0}}, sel[BYTE_W-1:0]};
        end else begin
            bus_rdata = {{BYTE_W{1'b0}}, sel[REG_W-1:BYTE_W]};
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    localparam int NUM_REGS  = NUM_TIMERS * 2,
    localparam int ADDR_W    = $clog2(NUM_REGS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_word,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic [NUM_TIMERS-1:0] irq_pulse
);
    logic [NUM_REGS-1:0][REG_W-1:0] reg_q;
    logic [NUM_REGS-1:0][REG_W-1:0] reg_nxt;
    logic [NUM_TIMERS-1:0]          restart;

    dit_regfile #(.NUM_TIMERS(NUM_TIMERS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reg_q     (reg_q),
        .reg_nxt   (reg_nxt),
        .restart   (restart)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        dit_timer_core core_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (restart[t]),
            .presc_nxt (reg_nxt[2*t]),
            .div_nxt   (reg_nxt[2*t+1]),
            .irq       (irq_pulse[t])
        );
    end

    dit_readmux #(.NUM_TIMERS(NUM_TIMERS)) rd_i (
        .reg_q     (reg_q),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    localparam int NUM_REGS  = NUM_TIMERS * 2,
    localparam int ADDR_W    = $clog2(NUM_REGS) + 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr,
    input logic                           bus_word,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [NUM_REGS-1:0][REG_W-1:0] reg_q,
    input logic [NUM_TIMERS-1:0]          restart,
    input logic [NUM_TIMERS-1:0]          irq_pulse
);
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_t
        p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[t] |=> !irq_pulse[t]);

        p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            restart[t] |=> !irq_pulse[t]);

        p_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((reg_q[2*t] == '0) || (reg_q[2*t+1] == '0)) |-> !irq_pulse[t]);
    end

    for (genvar w = 0; w < NUM_REGS; w++) begin : g_w
        p_lo_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !bus_word && (bus_addr == ADDR_W'(2*w+1)))
            |=> (reg_q[w][REG_W-1:BYTE_W] == $past(reg_q[w][REG_W-1:BYTE_W])));

        p_hi_keeps_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !bus_word && (bus_addr == ADDR_W'(2*w)))
            |=> (reg_q[w][BYTE_W-1:0] == $past(reg_q[w][BYTE_W-1:0])));

        p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (reg_q[w] == '1));
    end
endmodule

bind dual_interval_timer dit_checker #(.NUM_TIMERS(NUM_TIMERS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .reg_q     (reg_q),
    .restart   (restart),
    .irq_pulse (irq_pulse)
);

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_pulse;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    // {prescale, divide, expected period (0 = no pulse)} for timer 1
    localparam logic [47:0] VEC [7] = '{
        {16'd1, 16'd1, 16'd4},
        {16'd2, 16'd3, 16'd12},
        {16'd0, 16'd5, 16'd0},
        {16'd4, 16'd1, 16'd10},
        {16'd3, 16'd0, 16'd0},
        {16'd1, 16'd9, 16'd20},
        {16'd7, 16'd2, 16'd24}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic word, input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd(input logic word, input logic [2:0] a, output logic [15:0] d);
        bus_word = word; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_word = 1'b1;
    endtask

    // cycles until pulse on timer k, counting from start; 0 if none within lim
    task automatic wait_pulse(input int k, input int start, input int lim, output int n);
        int c;
        c = start;
        n = 0;
        while (c < lim) begin
            @(negedge clk);
            c++;
            if (irq_pulse[k]) begin
                n = c;
                break;
            end
        end
    endtask

    task automatic quiet(input int k, input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irq_pulse[k]) seen++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int n;
        int s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 4; w++) begin
            rd(1'b1, 3'(2*w), d);
            check("R1 reset value", int'(d), 16'hFFFF);
        end
        quiet(0, 60, s); check("R1 timer1 idle", s, 0);
        quiet(1, 10, s); check("R1 timer2 idle", s, 0);

        // R2/R3/R4: vector table on timer 1
        foreach (VEC[i]) begin
            int p, dv, e;
            p  = int'(VEC[i][47:32]);
            dv = int'(VEC[i][31:16]);
            e  = int'(VEC[i][15:0]);
            wr(1'b1, 3'd0, 16'(p));
            wr(1'b1, 3'd2, 16'(dv));
            if (e == 0) begin
                quiet(0, 60, s);
                check("R4 zero parks timer", s, 0);
            end else begin
                wait_pulse(0, 0, 200, n);
                check("R2 first period", n, e);
                @(negedge clk);
                check("R8 one-cycle pulse", int'(irq_pulse[0]), 0);
                wait_pulse(0, 1, 200, n);
                check("R3 reload period", n, e);
            end
        end

        // R5: word rewrite mid-period restarts (N = 16)
        wr(1'b1, 3'd0, 16'd3);
        wr(1'b1, 3'd2, 16'd3);
        repeat (10) @(negedge clk);
        wr(1'b1, 3'd0, 16'd3);
        wait_pulse(0, 0, 100, n);
        check("R5 word write restarts", n, 16);
        // R5: byte write of low divide byte restarts
        repeat (13) @(negedge clk);
        wr(1'b0, 3'd3, 16'h0003);
        wait_pulse(0, 0, 100, n);
        check("R5 byte write restarts", n, 16);

        // R4: zero written into running timer
        wr(1'b1, 3'd0, 16'd0);
        quiet(0, 60, s);
        check("R4 halted by zero write", s, 0);

        // R9: timer 2 (N = 10) not disturbed by a timer 1 write one edge later
        wr(1'b1, 3'd4, 16'd1);
        wr(1'b1, 3'd6, 16'd4);
        wr(1'b1, 3'd0, 16'd3);
        wait_pulse(1, 0, 100, n);
        check("R9 timer2 phase kept", n, 9);
        wait_pulse(0, n, 100, n);
        check("R9 timer1 own period", n, 16);

        // R7: layout and readback
        wr(1'b1, 3'd0, 16'h1111);
        wr(1'b1, 3'd2, 16'h2222);
        wr(1'b1, 3'd4, 16'h3333);
        wr(1'b1, 3'd6, 16'h1234);
        rd(1'b1, 3'd0, d); check("R7 word0", int'(d), 16'h1111);
        rd(1'b1, 3'd2, d); check("R7 word1", int'(d), 16'h2222);
        rd(1'b1, 3'd4, d); check("R7 word2", int'(d), 16'h3333);
        rd(1'b1, 3'd6, d); check("R7 word3", int'(d), 16'h1234);

        // R6: big-endian byte access
        wr(1'b0, 3'd6, 16'h00AB);
        rd(1'b1, 3'd6, d); check("R6 high byte write", int'(d), 16'hAB34);
        wr(1'b0, 3'd7, 16'h00CD);
        rd(1'b1, 3'd6, d); check("R6 low byte write", int'(d), 16'hABCD);
        rd(1'b0, 3'd6, d); check("R6 byte read even", int'(d), 16'h00AB);
        rd(1'b0, 3'd7, d); check("R6 byte read odd", int'(d), 16'h00CD);
        rd(1'b1, 3'd4, d); check("R6 neighbour untouched", int'(d), 16'h3333);

        // R2 via byte writes on timer 2: prescale 0x0001, divide 0x0002 -> 6
        wr(1'b0, 3'd4, 16'h0000);
        wr(1'b0, 3'd5, 16'h0001);
        wr(1'b0, 3'd6, 16'h0000);
        wr(1'b0, 3'd7, 16'h0002);
        wait_pulse(1, 0, 100, n);
        check("R2 timer2 byte-programmed period", n, 6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule